// File: doc/BRIEF.md
# Serial Control Register Port

This block is the host-facing control port of a voice and data baseband front end. A host controller reaches it over three lines: a serial clock, a direction line and a data line. The data line is split here into an input, an output and an output enable, so that a pad cell can form the bidirectional wire. While the direction line is high, the host shifts in a write frame. The frame is a 2-bit register address followed by 8 data bits, both sent most significant bit first. The addressed register is updated when the direction line falls. While the direction line is low, the host clocks the most recently received modem byte out of the port. A read carries no address.

The four write-only registers are decoded into the control fields that the rest of the chip consumes. These fields are the power mode and its per-path enables, the scrambler enable and inversion key, the emphasis and compander enables, the sync pattern select, the path switches, four volume codes, and a test-mode flag. A frame-sync detector elsewhere in the chip can set the frame-detect enable bit at any time. A reset loads defined defaults.

All host lines are assumed to be already synchronous to `clk`. They are sampled on every rising edge of `clk`, and the edges of the serial clock and of the direction line are found by comparing each sample with the previous one.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset the outputs are as follows. frame_sel=1, pwr_mode=2, frame_det_en=0, scramble_en=0, tx_clk_hold=1, tx_sel_msk=0, rx_mute=0, rx_gain_sw=0, test_mode=0, comp_en=1, emph_en=1, pat_sel=0, inv_key=1. The volume codes are vol_tx=8, vol_mod=8, vol_dem=8 and vol_rcv=4; each of these is the 0 dB code.
- R2: While dir is high, sdi is captured on each cycle where sclk is seen rising. The first two captured bits form the address, MSB first, and the next eight form the data, MSB first. The addressed register takes its new value on the clock edge at which dir is first sampled low.
- R3: A frame that holds fewer than 10 captured bits when dir falls changes no register. Bits captured after the tenth are ignored.
- R4: Register 0 is decoded as follows. Bit 7 drives frame_sel, bits 6:5 drive pwr_mode, bit 4 drives frame_det_en, bit 3 is the inverse of scramble_en (0 means the scrambler is on), bit 2 drives tx_clk_hold, bit 1 drives tx_sel_msk and bit 0 drives rx_mute.
- R5: The power mode enables the paths cumulatively. rx_msk_en=1 when pwr_mode>=1, tx_msk_en=1 when pwr_mode>=2, and voice_en=1 only when pwr_mode=3.
- R6: Register 1 is decoded as follows. Bit 3 drives rx_gain_sw and bits 2:0 drive vol_rcv. test_mode is 1 when any of bits 7:4 of register 1 is 0.
- R7: Registers 2 and 3 are decoded as follows. In register 2, bits 7:4 drive vol_mod and bits 3:0 drive vol_tx. In register 3, bit 7 drives comp_en, bit 6 drives emph_en, bit 5 drives pat_sel, bit 4 drives inv_key and bits 3:0 drive vol_dem.
- R8: A high frame_lock_set sets frame_det_en on the next clock edge. If it coincides with the commit of a write to register 0, frame_det_en ends at 1 and the other bits take the written data.
- R9: sdo_oe is the inverse of dir. While dir is low, sdo presents a snapshot of rx_data, MSB first, and advances one bit on each sclk rise. The snapshot is taken while no read is in progress, and again after the eighth rise, so a change of rx_data in the middle of a read does not alter the byte being read.
- R10: Read clocks (sclk activity while dir is low) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all host lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| dir | input | 1 | Direction: high selects write, low selects read |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the data pad |
| rx_data | input | 8 | Latest received modem byte |
| frame_lock_set | input | 1 | Pulse from the sync detector that sets frame_det_en |
| frame_sel | output | 1 | Flag pin selects the receive-byte flag (1) or the sync-pulse flag (0) |
| pwr_mode | output | 2 | Power mode code |
| frame_det_en | output | 1 | Frame detection enable |
| scramble_en | output | 1 | Spectrum-inversion scrambler on |
| tx_clk_hold | output | 1 | Holds the modem transmit clock high |
| tx_sel_msk | output | 1 | Transmit path selects modem data |
| rx_mute | output | 1 | Receive voice path muted |
| rx_msk_en | output | 1 | Receive modem powered |
| tx_msk_en | output | 1 | Transmit modem powered |
| voice_en | output | 1 | Voice paths powered |
| comp_en | output | 1 | Compander in path |
| emph_en | output | 1 | Emphasis in path |
| pat_sel | output | 1 | Sync pattern select |
| inv_key | output | 1 | Inversion carrier select |
| rx_gain_sw | output | 1 | Receive level switch |
| test_mode | output | 1 | Test mode entered |
| vol_tx | output | 4 | Transmit input volume code |
| vol_mod | output | 4 | Modulator output volume code |
| vol_dem | output | 4 | Demodulator input volume code |
| vol_rcv | output | 3 | Earpiece volume code |

## Verification
Two events can land on the same clock edge: the commit of a host write to register 0 and a set pulse from the sync detector on the frame-detect bit. The bench provokes this by raising frame_lock_set in the same cycle as it drops dir at the end of a frame that clears bit 4. It then expects frame_det_en to stay at 1 while every other field of register 0 takes the written value. A cycle-level reference model is compared against every output on every clock, so that a set pulse that is lost or applied late shows up at once.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int NREG     = 1 << ADDR_W;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int FLAG_REG = 0;
  localparam int FLAG_BIT = 4;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t reg_default(input int idx);
    case (idx)
      0:       return word_t'(8'hCC);
      1:       return word_t'(8'hF4);
      2:       return word_t'(8'h88);
      default: return word_t'(8'hD8);
    endcase
  endfunction
endpackage

// File: rtl/ssp_frame_rx.sv
module ssp_frame_rx #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              dir,
  input  logic              sdi,
  output logic              sclk_rise,
  output logic              commit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_q, dir_q;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [FRAME_W-1:0] sh, sh_n;
  logic               shift_en;

  assign sclk_rise = sclk & ~sclk_q;
  assign shift_en  = dir & sclk_rise & (cnt != FULL);

  always_comb begin
    cnt_n = cnt;
    sh_n  = sh;
    if (!dir) begin
      cnt_n = '0;
    end else if (shift_en) begin
      cnt_n = cnt + 1'b1;
      sh_n  = {sh[FRAME_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      sclk_q <= sclk;
      dir_q  <= dir;
      cnt    <= cnt_n;
      if (shift_en) sh <= sh_n;
    end
  end

  assign commit = dir_q & ~dir & (cnt == FULL);
  assign addr   = sh[FRAME_W-1 -: ADDR_W];
  assign data   = sh[DATA_W-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |=> cnt == '0); // R3
endmodule

// File: rtl/ssp_regbank.sv
module ssp_regbank #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int FLAG_REG = 0,
  parameter int FLAG_BIT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 data,
  input  logic                              flag_set,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs
);
  import ctl_serial_pkg::*;
  localparam int N = 1 << ADDR_W;

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic              hit, en;
    logic [DATA_W-1:0] nxt;

    assign hit = commit && (addr == ADDR_W'(g));

    if (g == FLAG_REG) begin : g_flag
      assign en = hit | flag_set;
      always_comb begin
        nxt = hit ? data : regs[g];
        if (flag_set) nxt[FLAG_BIT] = 1'b1;
      end
    end else begin : g_plain
      assign en  = hit;
      assign nxt = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= DATA_W'(reg_default(g));
      else if (en) regs[g] <= nxt;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !flag_set) |=> $stable(regs)); // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr != ADDR_W'(FLAG_REG)) |=> regs[$past(addr)] == $past(data)); // R2
  AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> regs[FLAG_REG][FLAG_BIT]); // R8
endmodule

// File: rtl/ssp_readout.sv
module ssp_readout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] rx_data,
  output logic              sdo
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] sh, sh_n;

  always_comb begin
    cnt_n = cnt;
    sh_n  = sh;
    if (dir) begin
      cnt_n = '0;
      sh_n  = rx_data;
    end else if (sclk_rise) begin
      if (cnt == LAST) begin
        cnt_n = '0;
        sh_n  = rx_data;
      end else begin
        cnt_n = cnt + 1'b1;
        sh_n  = sh << 1;
      end
    end else if (cnt == '0) begin
      sh_n = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else begin
      cnt <= cnt_n;
      sh  <= sh_n;
    end
  end

  assign sdo = sh[DATA_W-1];

  AST_RD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && sclk_rise && cnt == LAST) |=> sh == $past(rx_data)); // R9
  AST_RD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && sclk_rise && cnt != LAST) |=> sdo == $past(sh[DATA_W-2])); // R9
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              dir,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              frame_lock_set,
  output logic              frame_sel,
  output logic [1:0]        pwr_mode,
  output logic              frame_det_en,
  output logic              scramble_en,
  output logic              tx_clk_hold,
  output logic              tx_sel_msk,
  output logic              rx_mute,
  output logic              rx_msk_en,
  output logic              tx_msk_en,
  output logic              voice_en,
  output logic              comp_en,
  output logic              emph_en,
  output logic              pat_sel,
  output logic              inv_key,
  output logic              rx_gain_sw,
  output logic              test_mode,
  output logic [3:0]        vol_tx,
  output logic [3:0]        vol_mod,
  output logic [3:0]        vol_dem,
  output logic [2:0]        vol_rcv
);
  logic [1:0]              rst_pipe;
  logic                    rst_ni;
  logic                    sclk_rise, commit;
  logic [ADDR_W-1:0]       waddr;
  logic [DATA_W-1:0]       wdata;
  logic [NREG-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  ssp_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_ni), .sclk(sclk), .dir(dir), .sdi(sdi),
    .sclk_rise(sclk_rise), .commit(commit), .addr(waddr), .data(wdata)
  );

  ssp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .FLAG_REG(FLAG_REG), .FLAG_BIT(FLAG_BIT)) u_bank (
    .clk(clk), .rst_n(rst_ni), .commit(commit), .addr(waddr), .data(wdata),
    .flag_set(frame_lock_set), .regs(regs)
  );

  ssp_readout #(.DATA_W(DATA_W)) u_read (
    .clk(clk), .rst_n(rst_ni), .dir(dir), .sclk_rise(sclk_rise),
    .rx_data(rx_data), .sdo(sdo)
  );

  assign sdo_oe = ~dir;

  assign frame_sel    = regs[0][7];
  assign pwr_mode     = regs[0][6:5];
  assign frame_det_en = regs[0][4];
  assign scramble_en  = ~regs[0][3];
  assign tx_clk_hold  = regs[0][2];
  assign tx_sel_msk   = regs[0][1];
  assign rx_mute      = regs[0][0];

  assign rx_msk_en = |pwr_mode;
  assign tx_msk_en = pwr_mode[1];
  assign voice_en  = &pwr_mode;

  assign test_mode  = ~&regs[1][7:4];
  assign rx_gain_sw = regs[1][3];
  assign vol_rcv    = regs[1][2:0];

  assign vol_mod = regs[2][7:4];
  assign vol_tx  = regs[2][3:0];

  assign comp_en = regs[3][7];
  assign emph_en = regs[3][6];
  assign pat_sel = regs[3][5];
  assign inv_key = regs[3][4];
  assign vol_dem = regs[3][3:0];

  AST_MODE_ORDER: assert property (@(posedge clk) disable iff (!rst_ni)
    (voice_en |-> tx_msk_en) and (tx_msk_en |-> rx_msk_en)); // R5
  AST_TEST_EXIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit && waddr == ADDR_W'(1) && (&wdata[7:4])) |=> !test_mode); // R6
  AST_TEST_ENTER: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit && waddr == ADDR_W'(1) && !(&wdata[7:4])) |=> test_mode); // R6
endmodule

// File: tb/tb_ctl_serial_port.sv
module tb_ctl_serial_port;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, dir = 1'b0, sdi = 1'b0;
  logic frame_lock_set = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic sdo, sdo_oe, frame_sel, frame_det_en, scramble_en, tx_clk_hold;
  logic tx_sel_msk, rx_mute, rx_msk_en, tx_msk_en, voice_en, comp_en;
  logic emph_en, pat_sel, inv_key, rx_gain_sw, test_mode;
  logic [1:0] pwr_mode;
  logic [3:0] vol_tx, vol_mod, vol_dem;
  logic [2:0] vol_rcv;

  ctl_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .dir(dir), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .frame_lock_set(frame_lock_set),
    .frame_sel(frame_sel), .pwr_mode(pwr_mode), .frame_det_en(frame_det_en),
    .scramble_en(scramble_en), .tx_clk_hold(tx_clk_hold), .tx_sel_msk(tx_sel_msk),
    .rx_mute(rx_mute), .rx_msk_en(rx_msk_en), .tx_msk_en(tx_msk_en),
    .voice_en(voice_en), .comp_en(comp_en), .emph_en(emph_en), .pat_sel(pat_sel),
    .inv_key(inv_key), .rx_gain_sw(rx_gain_sw), .test_mode(test_mode),
    .vol_tx(vol_tx), .vol_mod(vol_mod), .vol_dem(vol_dem), .vol_rcv(vol_rcv)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m [4];
  bit         q [$];
  bit         psclk, pdir, rise, fall;
  int         ridx;
  logic [7:0] snap, fdata;
  logic [1:0] faddr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m[0] = 8'hCC; m[1] = 8'hF4; m[2] = 8'h88; m[3] = 8'hD8;
      q.delete(); psclk = 0; pdir = 0; ridx = 0; snap = 8'h00;
    end else begin
      rise = sclk && !psclk;
      fall = pdir && !dir;
      if (fall && q.size() >= 10) begin
        faddr = {q[0], q[1]};
        for (int i = 0; i < 8; i++) fdata[7-i] = q[2+i];
        m[faddr] = fdata;
      end
      if (frame_lock_set) m[0][4] = 1'b1;
      if (!dir) q.delete();
      else if (rise) q.push_back(sdi);
      if (dir) begin
        ridx = 0; snap = rx_data;
      end else if (rise) begin
        ridx++;
        if (ridx == 8) begin ridx = 0; snap = rx_data; end
      end else if (ridx == 0) begin
        snap = rx_data;
      end
      psclk = sclk; pdir = dir;
    end
    #(CLK_P/4);
    if (cmp_on) begin
      chk("R4 frame_sel", frame_sel, m[0][7]);
      chk("R4 pwr_mode", pwr_mode, m[0][6:5]);
      chk("R8 frame_det_en", frame_det_en, m[0][4]);
      chk("R4 scramble_en", scramble_en, !m[0][3]);
      chk("R4 tx_clk_hold", tx_clk_hold, m[0][2]);
      chk("R4 tx_sel_msk", tx_sel_msk, m[0][1]);
      chk("R4 rx_mute", rx_mute, m[0][0]);
      chk("R5 rx_msk_en", rx_msk_en, m[0][6:5] >= 2'd1);
      chk("R5 tx_msk_en", tx_msk_en, m[0][6:5] >= 2'd2);
      chk("R5 voice_en", voice_en, m[0][6:5] == 2'd3);
      chk("R6 rx_gain_sw", rx_gain_sw, m[1][3]);
      chk("R6 vol_rcv", vol_rcv, m[1][2:0]);
      chk("R6 test_mode", test_mode, !(&m[1][7:4]));
      chk("R7 vol_mod", vol_mod, m[2][7:4]);
      chk("R7 vol_tx", vol_tx, m[2][3:0]);
      chk("R7 ctl2", {comp_en, emph_en, pat_sel, inv_key}, m[3][7:4]);
      chk("R7 vol_dem", vol_dem, m[3][3:0]);
      chk("R2 regs vs model", {vol_mod, vol_tx}, m[2]);
      chk("R9 sdo_oe", sdo_oe, !dir);
      chk("R9 sdo", sdo, snap[7-ridx]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int nbits, input bit set_at_end);
    logic [11:0] bits;
    bits = {a, d, 2'b10};
    @(negedge clk) dir = 1'b1; sclk = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) sdi = bits[11-i]; sclk = 1'b0;
      @(negedge clk) sclk = 1'b1;
    end
    @(negedge clk) sclk = 1'b0;
    @(negedge clk) dir = 1'b0; frame_lock_set = set_at_end;
    @(negedge clk) frame_lock_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] b, input int swap_at, input logic [7:0] swap_val);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sclk = 1'b0;
      if (i == swap_at) rx_data = swap_val;
      @(negedge clk) b[7-i] = sdo; sclk = 1'b1;
    end
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state
    chk("R1 frame_sel", frame_sel, 1);
    chk("R1 pwr_mode", pwr_mode, 2);
    chk("R1 frame_det_en", frame_det_en, 0);
    chk("R1 scramble_en", scramble_en, 0);
    chk("R1 tx_clk_hold", tx_clk_hold, 1);
    chk("R1 tx_sel_msk/rx_mute", {tx_sel_msk, rx_mute}, 0);
    chk("R1 ctl2", {comp_en, emph_en, pat_sel, inv_key}, 4'b1101);
    chk("R1 volumes", {vol_tx, vol_mod, vol_dem, vol_rcv}, {4'd8, 4'd8, 4'd8, 3'd4});
    chk("R1 rx_gain_sw", rx_gain_sw, 0);
    chk("R1 test_mode", test_mode, 0);

    // R2 / R4 write to register 0
    wr(2'd0, 8'h5A, 10, 0);
    chk("R2 frame_sel", frame_sel, 0);
    chk("R4 pwr_mode", pwr_mode, 2);
    chk("R4 frame_det_en", frame_det_en, 1);
    chk("R4 scramble_en", scramble_en, 0);
    chk("R4 low bits", {tx_clk_hold, tx_sel_msk, rx_mute}, 3'b010);

    // R5 power modes
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, {1'b0, 2'(k), 5'b0}, 10, 0);
      chk("R5 enables", {rx_msk_en, tx_msk_en, voice_en},
          {k >= 1 ? 1'b1 : 1'b0, k >= 2 ? 1'b1 : 1'b0, k == 3 ? 1'b1 : 1'b0});
      chk("R4 scramble on", scramble_en, 1);
    end

    // R6 register 1 and test mode
    wr(2'd1, 8'h7B, 10, 0);
    chk("R6 test enter", test_mode, 1);
    chk("R6 fields", {rx_gain_sw, vol_rcv}, {1'b1, 3'd3});
    wr(2'd1, 8'hF2, 10, 0);
    chk("R6 test exit", test_mode, 0);
    chk("R6 fields b", {rx_gain_sw, vol_rcv}, {1'b0, 3'd2});

    // R7 registers 2 and 3
    wr(2'd2, 8'h3C, 10, 0);
    chk("R7 vol_mod/vol_tx", {vol_mod, vol_tx}, 8'h3C);
    wr(2'd3, 8'h27, 10, 0);
    chk("R7 ctl2", {comp_en, emph_en, pat_sel, inv_key}, 4'b0010);
    chk("R7 vol_dem", vol_dem, 7);

    // R3 short and long frames
    wr(2'd2, 8'h55, 9, 0);
    chk("R3 short frame dropped", {vol_mod, vol_tx}, 8'h3C);
    wr(2'd3, 8'h00, 0, 0);
    chk("R3 empty frame dropped", vol_dem, 7);
    wr(2'd2, 8'h96, 12, 0);
    chk("R3 extra bits ignored", {vol_mod, vol_tx}, 8'h96);

    // R8 sync set, alone and coincident with a write
    @(negedge clk) frame_lock_set = 1'b1;
    @(negedge clk) frame_lock_set = 1'b0;
    chk("R8 set alone", frame_det_en, 1);
    wr(2'd0, 8'h00, 10, 1);
    chk("R8 set wins", frame_det_en, 1);
    chk("R8 write rest", pwr_mode, 0);
    wr(2'd0, 8'h00, 10, 0);
    chk("R8 cleared by write", frame_det_en, 0);

    // R9 reads with snapshot protection
    rx_data = 8'hA5;
    repeat (2) @(negedge clk);
    chk("R9 oe in read", sdo_oe, 1);
    rd(b, 3, 8'h3C);
    chk("R9 first byte", b, 8'hA5);
    rd(b, 99, 8'h00);
    chk("R9 second byte", b, 8'h3C);

    // R10 registers untouched by reads
    chk("R10 vol after read", {vol_mod, vol_tx}, 8'h96);
    chk("R10 ctl after read", {frame_sel, pwr_mode, frame_det_en}, 4'b0000);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule